// File: doc/BRIEF.md
# I2C Second-Address and Continuous-Transfer Status Flags

This block holds two status flags for an I2C target that answers to a second 7-bit address besides its main one. The first flag records that the first byte after a START named the second address. The second flag records that the data path has asked for another byte (transmit buffer empty or receive buffer full) after such a match, or at any time when the block is not acting as a target. The shift register, bus arbitration and clock generation sit elsewhere and reach this block only as single-cycle event pulses.

Software reads both flags through a small register port. A flag clears only when software writes 0 to it after reading it as 1. A START, controller mode and the interrupt-acknowledge pulse also clear the flags, each as described below. A hardware event that sets a flag always beats a clear in the same cycle. An event that arrives between the read and the write cancels the pending clear, so no event is lost.

Top module: `i2c_dual_addr_flags`

## Requirements
- R1: After reset both flags are 0 and `reg_rdata` reads 2'b00 (bit 0 second-address flag, bit 1 continuous flag).
- R2: In target receive mode (`is_master`=0, `is_tx`=0) with `alt_fmt`=0, a `frame_valid` pulse on the first byte after a START sets the second-address flag when `frame_byte[7:1]` equals `sec_addr`. Bit 0 of the byte, the direction bit, is ignored.
- R3: The flag does not set if the byte is not the first after a START, if the address differs, if `alt_fmt`=1, or if `is_tx`=1.
- R4: A `start_det` pulse clears the second-address flag in the next cycle. A `frame_valid` in the same cycle as `start_det` is ignored, and the byte after it counts as the first frame.
- R5: While `is_master`=1 the second-address flag is held at 0, and no frame can set it.
- R6: A `reg_wr` with data bit k = 0 clears flag k only if flag k was read as 1 by an earlier `reg_rd`. Any write ends the pending clear of both flags. A write of 0 with no prior read of 1 leaves the flag unchanged.
- R7: A hardware set of a flag between the read and the write cancels that pending clear. A hardware set in the same cycle as any clear leaves the flag at 1.
- R8: In target mode a `tdre_set` or `rdrf_set` pulse sets the continuous flag only while the second-address flag is 1.
- R9: In controller mode a `tdre_set` or `rdrf_set` pulse always sets the continuous flag.
- R10: An `irq_clr` pulse clears the continuous flag in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | START condition seen (pulse) |
| frame_valid | input | 1 | A received byte is valid (pulse) |
| frame_byte | input | 8 | Received byte: address in [7:1], direction in [0] |
| sec_addr | input | 7 | Second target address |
| is_master | input | 1 | 1 = controller mode |
| is_tx | input | 1 | 1 = transmit mode |
| alt_fmt | input | 1 | 1 = second address disabled by format select |
| tdre_set | input | 1 | Transmit buffer became empty (pulse) |
| rdrf_set | input | 1 | Receive buffer became full (pulse) |
| irq_clr | input | 1 | Interrupt-request flag cleared (pulse) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Write data, one bit per flag |
| reg_rdata | output | 2 | Current flags |
| sec_match_flag | output | 1 | Second-address flag |
| cont_flag | output | 1 | Continuous-transfer flag |

## Verification
Two pairs of functions can land in the same cycle. The first is a hardware set of the continuous flag and a clear of it, either by `irq_clr` or by an armed software write. The second is a START and a frame strobe. The bench drives each pair on the same clock edge, and also drives a set pulse between a read and the write that follows it. It judges the result against a behavioural model, which must show the set winning, the pending clear dropped, and the frame ignored.

// File: rtl/i2cdf_pkg.sv
package i2cdf_pkg;
   localparam int FLAG_SEC  = 0;
   localparam int FLAG_CONT = 1;
   localparam int NUM_FLAGS = 2;

   typedef struct packed {
      logic set;
      logic clr;
   } flag_evt_t;
endpackage

// File: rtl/i2cdf_addr_match.sv
module i2cdf_addr_match #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              frame_valid,
   input  logic [ADDR_W:0]   frame_byte,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              enable,
   output logic              hit
);
   logic first_q;
   logic addr_eq;

   assign addr_eq = (frame_byte[ADDR_W:1] == own_addr);
   assign hit     = frame_valid & first_q & ~start_det & enable & addr_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           first_q <= 1'b0;
      else if (start_det)   first_q <= 1'b1;
      else if (frame_valid) first_q <= 1'b0;
   end

   // R3
   first_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !start_det) |=> !first_q);
endmodule

// File: rtl/i2cdf_flag_cell.sv
module i2cdf_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic rd_stb,
   input  logic wr_stb,
   input  logic wr_bit,
   output logic flag
);
   logic arm_q;
   logic sw_clr;

   assign sw_clr = wr_stb & ~wr_bit & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (hw_set)               flag <= 1'b1;
         else if (hw_clr || sw_clr) flag <= 1'b0;

         if (hw_set || hw_clr || wr_stb) arm_q <= 1'b0;
         else if (rd_stb && flag)        arm_q <= 1'b1;
      end
   end

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag);
   // R6
   unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !arm_q && !hw_set && !hw_clr) |=> (flag == $past(flag)));
endmodule

// File: rtl/i2c_dual_addr_flags.sv
module i2c_dual_addr_flags
   import i2cdf_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_det,
   input  logic              frame_valid,
   input  logic [ADDR_W:0]   frame_byte,
   input  logic [ADDR_W-1:0] sec_addr,
   input  logic              is_master,
   input  logic              is_tx,
   input  logic              alt_fmt,
   input  logic              tdre_set,
   input  logic              rdrf_set,
   input  logic              irq_clr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [1:0]        reg_wdata,
   output logic [1:0]        reg_rdata,
   output logic              sec_match_flag,
   output logic              cont_flag
);
   localparam int BYTE_W = ADDR_W + 1;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
         $error("ADDR_W out of range");
      end
   endgenerate

   flag_evt_t [NUM_FLAGS-1:0] evt;
   logic      [NUM_FLAGS-1:0] flags;
   logic                      hit;
   logic                      buf_evt;

   i2cdf_addr_match #(.ADDR_W(ADDR_W)) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_det   (start_det),
      .frame_valid (frame_valid),
      .frame_byte  (frame_byte[BYTE_W-1:0]),
      .own_addr    (sec_addr),
      .enable      (~is_master & ~is_tx & ~alt_fmt),
      .hit         (hit)
   );

   assign buf_evt              = tdre_set | rdrf_set;
   assign evt[FLAG_SEC].set    = hit;
   assign evt[FLAG_SEC].clr    = start_det | is_master;
   assign evt[FLAG_CONT].set   = buf_evt & (is_master | flags[FLAG_SEC]);
   assign evt[FLAG_CONT].clr   = irq_clr;

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         i2cdf_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (evt[i].set),
            .hw_clr (evt[i].clr),
            .rd_stb (reg_rd),
            .wr_stb (reg_wr),
            .wr_bit (reg_wdata[i]),
            .flag   (flags[i])
         );
      end
   endgenerate

   assign reg_rdata      = flags;
   assign sec_match_flag = flags[FLAG_SEC];
   assign cont_flag      = flags[FLAG_CONT];

   // R5
   master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_master |=> !sec_match_flag);
   // R4
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sec_match_flag);
   // R9
   master_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && (tdre_set || rdrf_set)) |=> cont_flag);
   // R10
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !tdre_set && !rdrf_set) |=> !cont_flag);
   // R8
   slave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_master && !sec_match_flag && !cont_flag) |=> !cont_flag);
endmodule

// File: tb/i2c_dual_addr_flags_bench.sv
module i2c_dual_addr_flags_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_det = 0, frame_valid = 0, is_master = 0, is_tx = 0, alt_fmt = 0;
   logic       tdre_set = 0, rdrf_set = 0, irq_clr = 0, reg_rd = 0, reg_wr = 0;
   logic [7:0] frame_byte = 8'h00;
   logic [6:0] sec_addr = 7'h2A;
   logic [1:0] reg_wdata = 2'b00;
   logic [1:0] reg_rdata;
   logic       sec_match_flag, cont_flag;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   i2c_dual_addr_flags u_i2c_dual_addr_flags (
      .clk(clk), .rst_n(rst_n), .start_det(start_det), .frame_valid(frame_valid),
      .frame_byte(frame_byte), .sec_addr(sec_addr), .is_master(is_master),
      .is_tx(is_tx), .alt_fmt(alt_fmt), .tdre_set(tdre_set), .rdrf_set(rdrf_set),
      .irq_clr(irq_clr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sec_match_flag(sec_match_flag), .cont_flag(cont_flag));

   // behavioural reference model
   int m_flag[2];
   int m_armed[2];
   int m_first;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_flag = '{0, 0}; m_armed = '{0, 0}; m_first = 0;
      end else begin
         int setv[2];
         int clrv[2];
         int old[2];
         old = m_flag;
         setv[0] = (frame_valid && m_first == 1 && !start_det && !is_master && !is_tx
                    && !alt_fmt && frame_byte[7:1] == sec_addr) ? 1 : 0;
         clrv[0] = (start_det || is_master) ? 1 : 0;
         setv[1] = ((tdre_set || rdrf_set) && (is_master || old[0] == 1)) ? 1 : 0;
         clrv[1] = irq_clr ? 1 : 0;
         for (int k = 0; k < 2; k++) begin
            bit wclr;
            wclr = reg_wr && reg_wdata[k] == 1'b0 && m_armed[k] == 1;
            if (setv[k] == 1)               m_flag[k] = 1;
            else if (clrv[k] == 1 || wclr)  m_flag[k] = 0;
            if (setv[k] == 1 || clrv[k] == 1 || reg_wr) m_armed[k] = 0;
            else if (reg_rd && old[k] == 1)            m_armed[k] = 1;
         end
         if (start_det)        m_first = 1;
         else if (frame_valid) m_first = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (sec_match_flag !== m_flag[0][0] || cont_flag !== m_flag[1][0]) begin
            errors++;
            $display("FAIL R2 R8 model compare: actual sec=%0b cont=%0b expected sec=%0d cont=%0d",
                     sec_match_flag, cont_flag, m_flag[0], m_flag[1]);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_all();
      start_det = 0; frame_valid = 0; tdre_set = 0; rdrf_set = 0;
      irq_clr = 0; reg_rd = 0; reg_wr = 0;
   endtask

   task automatic cyc();
      @(negedge clk); idle_all();
   endtask

   task automatic do_start();
      @(negedge clk); start_det = 1; cyc();
   endtask

   task automatic do_frame(input logic [7:0] b);
      @(negedge clk); frame_valid = 1; frame_byte = b; cyc();
   endtask

   task automatic do_read();
      @(negedge clk); reg_rd = 1; cyc();
   endtask

   task automatic do_write(input logic [1:0] d);
      @(negedge clk); reg_wr = 1; reg_wdata = d; cyc();
   endtask

   task automatic do_buf(input bit tx);
      @(negedge clk); if (tx) tdre_set = 1; else rdrf_set = 1; cyc();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      chk("R1 reset rdata", reg_rdata, 0);
      chk("R1 reset cont", cont_flag, 0);

      do_start(); do_frame({7'h2A, 1'b1});
      chk("R2 match with dir bit 1", sec_match_flag, 1);
      do_start();
      chk("R4 start clears", sec_match_flag, 0);
      do_frame({7'h15, 1'b0});
      chk("R3 mismatch", sec_match_flag, 0);
      do_frame({7'h2A, 1'b0});
      chk("R3 not first frame", sec_match_flag, 0);
      alt_fmt = 1; do_start(); do_frame({7'h2A, 1'b0});
      chk("R3 format select", sec_match_flag, 0);
      alt_fmt = 0; is_tx = 1; do_start(); do_frame({7'h2A, 1'b0});
      chk("R3 transmit", sec_match_flag, 0);
      is_tx = 0;

      @(negedge clk); start_det = 1; frame_valid = 1; frame_byte = {7'h2A, 1'b0}; cyc();
      chk("R4 frame with start ignored", sec_match_flag, 0);
      do_frame({7'h2A, 1'b0});
      chk("R4 next frame is first", sec_match_flag, 1);

      do_buf(1);
      chk("R8 set while matched", cont_flag, 1);
      do_write(2'b00);
      chk("R6 unarmed write sec", sec_match_flag, 1);
      chk("R6 unarmed write cont", cont_flag, 1);
      do_read();
      chk("R6 read value", reg_rdata, 3);
      do_write(2'b01);
      chk("R6 armed clear cont", cont_flag, 0);
      chk("R6 write 1 keeps sec", sec_match_flag, 1);
      do_write(2'b00);
      chk("R6 arming consumed", sec_match_flag, 1);
      do_read(); do_write(2'b00);
      chk("R6 armed clear sec", sec_match_flag, 0);
      do_buf(0);
      chk("R8 no set unmatched", cont_flag, 0);

      do_start(); do_frame({7'h2A, 1'b0});
      chk("R2 matched again", sec_match_flag, 1);
      is_master = 1; cyc();
      chk("R5 master clears", sec_match_flag, 0);
      do_start(); do_frame({7'h2A, 1'b0});
      chk("R5 no set in master", sec_match_flag, 0);
      do_buf(0);
      chk("R9 master set", cont_flag, 1);
      @(negedge clk); irq_clr = 1; cyc();
      chk("R10 irq clears", cont_flag, 0);
      @(negedge clk); irq_clr = 1; tdre_set = 1; cyc();
      chk("R7 set beats irq clear", cont_flag, 1);

      do_read(); do_buf(0); do_write(2'b00);
      chk("R7 arming cancelled", cont_flag, 1);
      do_read();
      @(negedge clk); reg_wr = 1; reg_wdata = 2'b00; tdre_set = 1; cyc();
      chk("R7 set beats write clear", cont_flag, 1);
      do_read(); do_write(2'b00);
      chk("R6 clear in master", cont_flag, 0);

      repeat (2) cyc();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule